// File: doc/BRIEF.md
# Cross-Channel Pixel Normalizer

This block performs local response normalization across feature maps. For a single (row, column) position it collects one signed 16-bit pixel from each of the `M` maps. Each pixel is then divided by a power of the energy of its neighbours at that same position. The neighbourhood is a window of `n` consecutive maps centred on the pixel's own map, and the window is clipped at both ends of the stack. The exponent is fixed at 0.75. The inverse power comes from a 256-entry gain table, and the normalization itself is a multiply.

A position is loaded one pixel per beat through a valid/ready input. Each beat carries the pixel's map index. `TL` parallel processing elements then work on `TL` adjacent maps at a time. Each element spends `n` cycles accumulating squares and then four cycles in the scale, offset, table and multiply steps. Every group of results leaves as one output beat that is `TL` lanes wide. The groups come out in ascending map order, and the number of output maps equals the number of input maps. The window size, the additive constant and the scale are sampled once per position.

Top module: `lrn_xmap`

## Requirements
- R1: For map m, lane output equals floor(a[m]·g / 2^14) saturated to signed 16 bits, where g is the table gain selected from the window sum s = Σ a[j]² over j = m−n/2 … m+n/2 at the same position, with signed 16-bit pixels.
- R2: Window members below map 0 or above map M−1 are dropped from the sum. The window does not wrap, and the dropped maps contribute nothing.
- R3: The sum of squares is a 32-bit unsigned value that saturates at 2^32−1 and does not wrap.
- R4: The scaled term is (α·s)>>16. The denominator d = k + scaled saturates at 2^32−1. The table index is 255 when d > 65535 and d[15:8] otherwise. Entry i holds round(16384·(i+0.5)^−0.75). The final product saturates to the range −32768 … 32767.
- R5: Each input beat writes its pixel into the slot named by `in_map`, in whatever order the beats arrive. The M-th accepted beat completes the position.
- R6: Each output beat carries maps `out_map`+t in lane t (bits t·16 +: 16). `out_map` steps 0, TL, 2·TL … M−TL, and `in_ready` returns after the last group is accepted.
- R7: `out_valid` rises exactly n+4 cycles after the accepting edge of the last input beat, or n+4 cycles after the accepting edge of the previous output beat. It is low in the cycle after every accepted output.
- R8: `in_ready` is high only while a position is being loaded and is never high together with `out_valid`. While `out_valid` is high and `out_ready` is low, `out_data` and `out_map` hold.
- R9: `cfg_n`, `cfg_k` and `cfg_alpha` are sampled on the edge that accepts the last pixel of a position. Later changes to them do not affect that position's results.
- R10: After reset, `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_k | input | 16 | Additive constant k, 8 fraction bits |
| cfg_alpha | input | 16 | Scale α, 16 fraction bits |
| cfg_n | input | 3 | Window size n, odd, 1 to 7 |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block is loading a position |
| in_data | input | DW | Signed input pixel |
| in_map | input | AW | Map index of the input pixel |
| out_valid | output | 1 | Output group valid |
| out_ready | input | 1 | Downstream accepts the group |
| out_data | output | TL·DW | TL signed normalized pixels |
| out_map | output | AW | Map index of lane 0 |

## Verification
The bench builds the block with its defaults: eight maps and two lanes. At that size every window of 3, 5 and 7 touches an edge for some map, so clipping at both ends shows in each position. Full-scale negative pixels with the widest window push the sum of squares into saturation, and a zero denominator drives the output multiply into saturation. Running the bench with map order reversed, with output backpressure, and with the configuration scrambled after every load checks the slot addressing, the hold rule and the sampling point.

// File: rtl/lrn_xmap.sv
module lrn_xmap #(
  parameter int M  = 8,
  parameter int DW = 16,
  parameter int TL = 2,
  localparam int AW = (M > 1) ? $clog2(M) : 1,
  localparam int SW = 2 * DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cfg_k,
  input  logic [15:0]       cfg_alpha,
  input  logic [2:0]        cfg_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DW-1:0]     in_data,
  input  logic [AW-1:0]     in_map,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [TL*DW-1:0]  out_data,
  output logic [AW-1:0]     out_map
);

  typedef enum logic [2:0] {LOAD, ACC, SCL, DEN, LUT, MUL, OUTP} st_t;

  function automatic logic [15:0] gain_of(int i);
    real x;
    x = real'(i) + 0.5;
    return 16'($rtoi(16384.0 * $pow(x, -0.75) + 0.5));
  endfunction

  st_t                  st;
  logic signed [DW-1:0] stk [M];
  logic [AW:0]          lcnt;
  logic [2:0]           step, nq;
  logic [15:0]          kq, aq;
  logic [AW-1:0]        base;
  logic [15:0]          lut [256];

  for (genvar g = 0; g < 256; g++) begin : g_lut
    localparam logic [15:0] V = gain_of(g);
    assign lut[g] = V;
  end

  assign in_ready  = (st == LOAD);
  assign out_valid = (st == OUTP);
  assign out_map   = base;

  always_ff @(posedge clk)
    if (in_valid && in_ready) stk[in_map] <= $signed(in_data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= LOAD;
      lcnt <= '0;
      step <= '0;
      base <= '0;
      nq   <= 3'd1;
      kq   <= '0;
      aq   <= '0;
    end else begin
      case (st)
        LOAD: if (in_valid) begin
          lcnt <= lcnt + 1'b1;
          if (lcnt == (AW+1)'(M-1)) begin
            lcnt <= '0;
            kq   <= cfg_k;
            aq   <= cfg_alpha;
            nq   <= cfg_n;
            base <= '0;
            step <= '0;
            st   <= ACC;
          end
        end
        ACC: begin
          step <= step + 3'd1;
          if (step == nq - 3'd1) st <= SCL;
        end
        SCL: st <= DEN;
        DEN: st <= LUT;
        LUT: st <= MUL;
        MUL: st <= OUTP;
        OUTP: if (out_ready) begin
          step <= '0;
          if (base == AW'(M-TL)) st <= LOAD;
          else begin
            base <= base + AW'(TL);
            st   <= ACC;
          end
        end
        default: st <= LOAD;
      endcase
    end
  end

  for (genvar t = 0; t < TL; t++) begin : g_pe
    int                   j;
    logic [AW-1:0]        ci;
    logic signed [DW-1:0] px, cp;
    logic signed [SW-1:0] pr;
    logic [SW-1:0]        acc, sq, sclr;
    logic [SW:0]          sum, den;
    logic [7:0]           ix;
    logic [15:0]          gain;
    logic signed [DW+16:0] mp, q;
    logic signed [DW-1:0] res, rs;
    logic                 ovf;

    assign j    = int'(base) + t - int'(nq >> 1) + int'(step);
    assign px   = stk[j[AW-1:0]];
    assign pr   = px * px;
    assign sq   = (j >= 0 && j < M) ? pr : '0;
    assign sum  = {1'b0, acc} + {1'b0, sq};
    assign sclr = SW'(((SW+16)'(aq) * (SW+16)'(acc)) >> 16);
    assign den  = {1'b0, acc} + (SW+1)'(kq);
    assign ix   = (|acc[SW-1:16]) ? 8'hFF : acc[15:8];
    assign ci   = base + AW'(t);
    assign cp   = stk[ci];
    assign mp   = cp * $signed({1'b0, gain});
    assign q    = mp >>> 14;
    assign ovf  = !((&q[DW+16:DW-1]) || !(|q[DW+16:DW-1]));
    assign rs   = !ovf ? q[DW-1:0]
                : (q[DW+16] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}});

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        acc  <= '0;
        gain <= '0;
        res  <= '0;
      end else begin
        case (st)
          LOAD, OUTP: acc <= '0;
          ACC: acc <= sum[SW] ? '1 : sum[SW-1:0];
          SCL: acc <= sclr;
          DEN: acc <= den[SW] ? '1 : den[SW-1:0];
          LUT: gain <= lut[ix];
          MUL: res <= rs;
          default: ;
        endcase
      end
    end

    assign out_data[t*DW +: DW] = res;
  end

endmodule

// File: rtl/lrn_xmap_chk.sv
module lrn_xmap_chk #(
  parameter int M  = 8,
  parameter int DW = 16,
  parameter int TL = 2,
  localparam int AW = (M > 1) ? $clog2(M) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       cfg_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [TL*DW-1:0] out_data,
  input logic [AW-1:0]    out_map
);

  logic [AW:0] lc;
  logic [2:0]  nl;
  logic [3:0]  gap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lc  <= '0;
      nl  <= '0;
      gap <= '0;
    end else if (in_valid && in_ready) begin
      if (lc == (AW+1)'(M-1)) begin
        lc  <= '0;
        nl  <= cfg_n;
        gap <= '0;
      end else lc <= lc + 1'b1;
    end else if (out_valid && out_ready) gap <= '0;
    else if (gap != 4'hF) gap <= gap + 4'd1;
  end

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> gap == 4'(nl) + 4'd4);

  assert_gap_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_valid);

  assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_map));

  assert_map_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_map != AW'(M-TL) |=> out_map == $past(out_map) + AW'(TL));

  assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_map == AW'(M-TL) |=> in_ready);

endmodule

bind lrn_xmap lrn_xmap_chk #(.M(M), .DW(DW), .TL(TL)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_n(cfg_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_map(out_map)
);

// File: tb/lrn_xmap_tb.sv
module lrn_xmap_tb;
  localparam int M = 8, DW = 16, TL = 2, AW = 3, NB = M / TL;
  localparam longint MAXU = 64'hFFFF_FFFF;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic [15:0] cfg_k = 0, cfg_alpha = 0;
  logic [2:0]  cfg_n = 3'd1;
  logic in_valid = 0, in_ready, out_valid, out_ready = 1;
  logic [DW-1:0] in_data = 0;
  logic [AW-1:0] in_map = 0, out_map;
  logic [TL*DW-1:0] out_data;

  lrn_xmap u_dut (.*);

  int checks = 0, fails = 0;
  string tag = "R1";
  bit done = 0, bp = 0;

  int mstk [M];
  int eq [M];
  int lcnt = 0, cd = 0, mb = 0, mn = 1;
  bit active = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int gain_ref(int i);
    return $rtoi(16384.0 * $pow(real'(i) + 0.5, -0.75) + 0.5);
  endfunction

  function automatic void compute(int n, longint k, longint al);
    for (int m = 0; m < M; m++) begin
      longint s = 0, d, p, q;
      int h = n / 2, idx;
      for (int j = m - h; j <= m + h; j++)
        if (j >= 0 && j < M) s += longint'(mstk[j]) * mstk[j];
      if (s > MAXU) s = MAXU;
      d = k + ((al * s) >> 16);
      if (d > MAXU) d = MAXU;
      idx = (d > 65535) ? 255 : int'(d >> 8);
      p = longint'(mstk[m]) * gain_ref(idx);
      q = p >>> 14;
      if (q > 32767) q = 32767;
      if (q < -32768) q = -32768;
      eq[m] = int'(q);
    end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      lcnt = 0; active = 0; cd = 0; mb = 0;
    end else if (in_valid && !active) begin
      mstk[in_map] = int'($signed(in_data));
      lcnt++;
      if (lcnt == M) begin
        lcnt = 0; mn = cfg_n; mb = 0; active = 1; cd = mn + 4;
        compute(mn, cfg_k, cfg_alpha);
      end
    end else if (active && cd == 0 && out_ready) begin
      mb++;
      if (mb == NB) active = 0;
      else cd = mn + 4;
    end else if (active && cd > 0) cd--;
  end

  bit hold = 0;
  logic [TL*DW-1:0] pdata;
  logic [AW-1:0] pmap;

  always @(negedge clk) if (rst_n && !done) begin
    chk(in_ready == !active, "R8", "in_ready", in_ready, !active);
    chk(out_valid == (active && cd == 0), "R7", "out_valid", out_valid, active && cd == 0);
    if (hold) begin
      chk(out_data == pdata, "R8", "held data", out_data, pdata);
      chk(out_map == pmap, "R8", "held map", out_map, pmap);
    end
    if (out_valid && active && cd == 0) begin
      chk(out_map == AW'(mb * TL), "R6", "out_map", out_map, mb * TL);
      for (int t = 0; t < TL; t++)
        chk($signed(out_data[t*DW +: DW]) == eq[mb*TL+t], tag, "lane value",
            $signed(out_data[t*DW +: DW]), eq[mb*TL+t]);
    end
    hold  = out_valid && !out_ready;
    pdata = out_data;
    pmap  = out_map;
  end

  initial forever begin
    @(posedge clk); #1;
    out_ready = bp ? ($urandom_range(0, 2) != 0) : 1'b1;
  end

  task automatic send_pos(input int px [M], input bit rev, input int n, input int k, input int al);
    cfg_n = 3'(n); cfg_k = 16'(k); cfg_alpha = 16'(al);
    for (int i = 0; i < M; i++) begin
      int idx = rev ? M - 1 - i : i;
      if ($urandom_range(0, 3) == 0) begin
        in_valid = 0; @(posedge clk); #1;
      end
      in_valid = 1; in_data = 16'(px[idx]); in_map = AW'(idx);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      @(posedge clk); #1;
    end
    in_valid = 0;
    cfg_n = 3'($urandom_range(0, 3) * 2 + 1);   // R9: scramble after sampling edge
    cfg_k = 16'($urandom); cfg_alpha = 16'($urandom);
  endtask

  task automatic drain();
    @(negedge clk);
    while (active) @(negedge clk);
  endtask

  int px [M];

  initial begin
    repeat (2) @(negedge clk);
    chk(in_ready == 1'b1, "R10", "reset in_ready", in_ready, 1);
    chk(out_valid == 1'b0, "R10", "reset out_valid", out_valid, 0);
    @(posedge clk); #1 rst_n = 1;

    tag = "R1";
    for (int i = 0; i < M; i++) px[i] = $urandom_range(0, 4000) - 2000;
    send_pos(px, 0, 3, 256, 8192); drain();

    tag = "R2";   // ramp, widest window clipped at both ends
    for (int i = 0; i < M; i++) px[i] = 1000 * (i + 1);
    send_pos(px, 0, 7, 64, 40000); drain();

    tag = "R5";   // reversed arrival order
    for (int i = 0; i < M; i++) px[i] = $urandom_range(0, 60000) - 30000;
    send_pos(px, 1, 5, 512, 3000); drain();

    tag = "R3";   // sum of squares saturates
    for (int i = 0; i < M; i++) px[i] = -32768;
    send_pos(px, 0, 7, 0, 1); drain();

    tag = "R4";   // zero denominator, output saturates
    for (int i = 0; i < M; i++) px[i] = (i % 2) ? 32767 : -32768;
    send_pos(px, 0, 1, 0, 0); drain();
    for (int i = 0; i < M; i++) px[i] = $urandom_range(0, 20000) - 10000;
    send_pos(px, 1, 1, 300, 65535); drain();

    tag = "R8";   // output backpressure
    bp = 1;
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < M; i++) px[i] = $urandom_range(0, 65535) - 32768;
      send_pos(px, r[0], 2 * r + 3, $urandom_range(0, 65535), $urandom_range(0, 65535));
    end
    drain();
    bp = 0;

    tag = "R9";   // config changed right after the last pixel
    for (int i = 0; i < M; i++) px[i] = 500 * i - 1700;
    send_pos(px, 0, 5, 128, 20000); drain();

    repeat (5) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule